// File: doc/BRIEF.md
# Register-Programmed SPI Word Engine

This block moves single words between a host register port and a serial flash on one of four chip-select lines. Software programs a clock divider and a per-line device setup byte. It loads up to four 32-bit data registers and then writes a command. Each accepted read or write command shifts one word of 1 to 128 bits over a single data line in each direction. When the word ends, the engine reports completion in a status register.

The chip select stays asserted across words. Several commands can therefore build one continuous flash transaction, such as an opcode, then an address, then data. The line is released only by an explicit end-of-frame command. A command word of zero also releases it, and also abandons a word that is in flight. Register reads are combinational on the same address bus as writes.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset the status reads 0, all four chip-select outputs are 1 (inactive, since every polarity bit is 0), SCLK and MOSI are 0, and every data register reads 0.
- R2: With divider N in clock-control bits 15:0 and D in the device byte bits 4:3, a word of L bits keeps busy set for exactly (D + 2L)·(N + 1) clock cycles. Each SCLK level lasts N + 1 cycles.
- R3: While clock-control bit 31 is 0, an accepted word makes no progress: busy stays 1 and SCLK holds its idle level. Setting the bit lets the word complete.
- R4: Command bits 29:28 pick the chip select, bits 25:19 hold L − 1, and bits 18:16 hold the operation. During a word only the chosen line is driven to its active level.
- R5: Operation 2 (write) shifts out the low L bits of {data3, data2, data1, data0}, most significant bit first. Data3 (address 7) is the top word and data0 (address 4) is the bottom word.
- R6: Operation 1 (read) shifts in L bits from MISO, MSB first. It places them right-aligned in {data3..data0} and clears every bit above them.
- R7: After an accepted read or write command, busy (status bit 0) is 1 on the next cycle and word-complete (status bit 1) is 0. At the end of the word the status reads word-complete 1, busy 0.
- R8: Device-control byte cs·8 configures its line. Bit 0 sets the SCLK idle level, bit 1 sets the chip-select active level (1 means active high), bit 2 is the clock phase, and bits 4:3 give the number of idle SCLK half-periods before the first edge.
- R9: The chip select remains active between words until operation 4 is written. Operation 4 deactivates every line on the next cycle.
- R10: A command word of 0 aborts any word in flight and releases the chip select. Other operation codes (for example 7), and read or write commands issued while busy, change neither status, chip selects nor data.
- R11: With phase 0, data is sampled on the leading SCLK edge and changed on the trailing edge. With phase 1, data is changed on the leading edge and sampled on the trailing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address: 0 clock, 1 device, 2 command, 3 status, 4-7 data0-data3 |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| sclk | output | 1 | Serial clock |
| cs_out | output | 4 | Chip-select lines, level set by each polarity bit |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
Busy is due one cycle after the command edge. Its fall comes exactly (D + 2L)·(N + 1) cycles later, so the bench counts the falling-edge samples on which status shows busy and compares that count with the formula. A release command takes effect on the cycle after it is written, and the bench reads status and chip selects right after the write. Serial data is observed only through SCLK transitions seen between clock edges. MISO is therefore changed after the sampling edge the engine has just used, and MOSI is captured before the engine's next change.

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        sclk,
  output logic [3:0]  cs_out,
  output logic        mosi,
  input  logic        miso
);
  localparam int WMAX = 128;
  localparam int LW   = 7;
  localparam int HW   = 8;
  localparam logic [2:0] A_CLK = 3'd0, A_DC = 3'd1, A_CMD = 3'd2, A_STAT = 3'd3;
  localparam logic [2:0] OP_NONE = 3'd0, OP_RD = 3'd1, OP_WR = 3'd2, OP_END = 3'd4;

  logic            ck_en;
  logic [15:0]     ck_div, cnt;
  logic [31:0]     dc, cmd_q;
  logic [WMAX-1:0] dat, sh, rx, rx_nx;
  logic            busy, wc, open, is_rd, ph, mosi_q;
  logic [1:0]      sel, dcnt;
  logic [LW-1:0]   len;
  logic [HW-1:0]   hcnt;

  wire             wr_cmd  = reg_wr && reg_addr == A_CMD;
  wire [2:0]       op      = reg_wdata[18:16];
  wire             start   = wr_cmd && (op == OP_RD || op == OP_WR) && !busy;
  wire             stop    = wr_cmd && (op == OP_END || op == OP_NONE);
  wire [7:0]       nb      = dc[{reg_wdata[29:28], 3'b000} +: 8];
  wire [7:0]       cfg     = dc[{sel, 3'b000} +: 8];
  wire [WMAX-1:0]  sh_init = dat << (7'(WMAX-1) - reg_wdata[25:19]);
  wire [HW-1:0]    last    = {len, 1'b1};
  wire             tick    = busy && ck_en && cnt == ck_div;
  wire             run     = tick && dcnt == 2'd0;
  wire             lead    = !hcnt[0];
  wire             samp    = run && (lead != cfg[2]);
  wire             pres    = run && !is_rd && (cfg[2] ? lead : (!lead && hcnt != last));

  assign rx_nx = (samp && is_rd) ? {rx[WMAX-2:0], miso} : rx;
  assign sclk  = cfg[0] ^ ph;
  assign mosi  = mosi_q;

  always_comb
    for (int i = 0; i < 4; i++)
      cs_out[i] = (open && sel == 2'(i)) ? dc[8*i+1] : !dc[8*i+1];

  always_comb
    case (reg_addr)
      A_CLK:   reg_rdata = {ck_en, 15'd0, ck_div};
      A_DC:    reg_rdata = dc;
      A_CMD:   reg_rdata = cmd_q;
      A_STAT:  reg_rdata = {30'd0, wc, busy};
      default: reg_rdata = dat[{reg_addr[1:0], 5'b00000} +: 32];
    endcase

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_en <= 1'b0; ck_div <= '0; cnt <= '0; dc <= '0; cmd_q <= '0;
      dat <= '0; sh <= '0; rx <= '0; busy <= 1'b0; wc <= 1'b0; open <= 1'b0;
      is_rd <= 1'b0; ph <= 1'b0; mosi_q <= 1'b0; sel <= '0; dcnt <= '0;
      len <= '0; hcnt <= '0;
    end else begin
      if (reg_wr && reg_addr == A_CLK) begin
        ck_en  <= reg_wdata[31];
        ck_div <= reg_wdata[15:0];
      end
      if (reg_wr && reg_addr == A_DC) dc <= reg_wdata;
      if (reg_wr && reg_addr[2]) dat[{reg_addr[1:0], 5'b00000} +: 32] <= reg_wdata;

      if (busy && ck_en) cnt <= tick ? '0 : cnt + 16'd1;
      if (tick && dcnt != 2'd0) dcnt <= dcnt - 2'd1;
      if (run) begin
        ph   <= ~ph;
        hcnt <= hcnt + HW'(1);
      end
      rx <= rx_nx;
      if (pres) begin
        mosi_q <= sh[WMAX-1];
        sh     <= sh << 1;
      end
      if (run && hcnt == last) begin
        busy <= 1'b0;
        wc   <= 1'b1;
        if (is_rd) dat <= rx_nx;
      end

      if (start) begin
        busy <= 1'b1; wc <= 1'b0; open <= 1'b1; cmd_q <= reg_wdata;
        sel <= reg_wdata[29:28]; len <= reg_wdata[25:19]; is_rd <= op == OP_RD;
        cnt <= '0; hcnt <= '0; ph <= 1'b0; dcnt <= nb[4:3]; rx <= '0;
        if (op == OP_WR && !nb[2]) begin
          mosi_q <= sh_init[WMAX-1];
          sh     <= sh_init << 1;
        end else begin
          mosi_q <= 1'b0;
          sh     <= sh_init;
        end
      end
      if (stop) begin
        busy <= 1'b0; wc <= 1'b0; open <= 1'b0; ph <= 1'b0; mosi_q <= 1'b0;
        cmd_q <= reg_wdata;
      end
    end
  end
endmodule

module spi_cmd_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [2:0] reg_addr,
  input logic [2:0] cmd_op,
  input logic       busy,
  input logic       wc,
  input logic       sclk,
  input logic [3:0] cs_out,
  input logic [3:0] cs_pol
);
  wire       cmdw = reg_wr && reg_addr == 3'd2;
  wire [3:0] act  = ~(cs_out ^ cs_pol);

  p_busy_next_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmdw && (cmd_op == 3'd1 || cmd_op == 3'd2) && !busy |=> busy && !wc);
  p_wc_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wc) |-> $fell(busy));
  p_end_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmdw && (cmd_op == 3'd4 || cmd_op == 3'd0) |=> act == 4'd0 && !busy);
  p_one_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(act));
  p_cs_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> act != 4'd0);
  p_sclk_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && $past(!busy) && $stable(cs_pol) && !$past(reg_wr) |-> $stable(sclk));
endmodule

bind spi_cmd_engine spi_cmd_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .cmd_op(reg_wdata[18:16]), .busy(busy), .wc(wc), .sclk(sclk),
  .cs_out(cs_out), .cs_pol({dc[25], dc[17], dc[9], dc[1]})
);

// File: tb/spi_cmd_engine_bench.sv
`timescale 1ns/1ps
module spi_cmd_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n, reg_wr, miso;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        sclk, mosi;
  logic [3:0]  cs_out;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  spi_cmd_engine u_spi_cmd_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk(sclk),
    .cs_out(cs_out), .mosi(mosi), .miso(miso)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  function automatic logic [3:0] csx(input int s, input logic [31:0] d, input bit on);
    logic [3:0] r;
    for (int i = 0; i < 4; i++) r[i] = (on && i == s) ? d[8*i+1] : !d[8*i+1];
    return r;
  endfunction

  task automatic xfer(input int cs, input int len, input bit rdop, input logic [127:0] rpat,
                      input bit cpol, input bit cpha, input logic [31:0] dcv,
                      input int expcyc, output logic [127:0] cap);
    int cyc = 0, k = 0, guard = 0;
    logic prev, lead, csbad;
    logic [31:0] st;
    cap = '0; prev = cpol; csbad = 1'b0;
    miso = rdop ? rpat[len-1] : 1'b0;
    wr(3'd2, (32'(cs) << 28) | (32'(len-1) << 19) | (rdop ? 32'h0001_0000 : 32'h0002_0000));
    rd(3'd3, st);
    chk("R7 busy set after command", 128'(st[1:0]), 128'h1);
    while (1) begin
      if (sclk !== prev) begin
        lead = (prev == cpol);
        if (lead != cpha) begin
          cap = {cap[126:0], mosi};
          k++;
          if (k < len) miso = rdop ? rpat[len-1-k] : 1'b0;
        end
        prev = sclk;
      end
      rd(3'd3, st);
      if (!st[0]) break;
      cyc++;
      if (cs_out !== csx(cs, dcv, 1'b1)) csbad = 1'b1;
      guard++;
      if (guard > 5000) break;
      @(negedge clk);
    end
    chk("R7 word finishes", 128'(guard <= 5000), 128'h1);
    chk("R4 only addressed chip select active", 128'(csbad), 128'h0);
    if (expcyc >= 0) chk("R2 busy duration", 128'(cyc), 128'(expcyc));
    chk("R7 status at finish", 128'(st[1:0]), 128'h2);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(3'd3, v); chk("R1 status after reset", 128'(v), 128'h0);
    rd(3'd4, v); chk("R1 data0 after reset", 128'(v), 128'h0);
    chk("R1 chip selects after reset", 128'(cs_out), 128'hF);
    chk("R1 sclk and mosi after reset", 128'({sclk, mosi}), 128'h0);
  endtask

  task automatic t_write_mode0;
    logic [127:0] cap;
    wr(3'd1, 32'h0); wr(3'd0, 32'h8000_0001); wr(3'd4, 32'h0000_01A5);
    xfer(0, 8, 1'b0, '0, 1'b0, 1'b0, 32'h0, 32, cap);
    chk("R5 write byte MSB first", cap[7:0], 8'hA5);
    wr(3'd2, 32'h0004_0000);
    chk("R9 end of frame releases", 128'(cs_out), 128'hF);
  endtask

  task automatic t_read_mode0;
    logic [127:0] cap;
    logic [31:0] v;
    wr(3'd0, 32'h8000_0002); wr(3'd5, 32'hFFFF_FFFF);
    xfer(1, 12, 1'b1, 128'hB3C, 1'b0, 1'b0, 32'h0, 72, cap);
    rd(3'd4, v); chk("R6 R11 read 12 bits phase 0", 128'(v), 128'hB3C);
    rd(3'd5, v); chk("R6 upper data cleared", 128'(v), 128'h0);
    wr(3'd2, 32'h0004_0000);
  endtask

  task automatic t_mode3_delay;
    logic [127:0] cap;
    logic [31:0] dcv = 32'h0017_0000;
    wr(3'd1, dcv); wr(3'd0, 32'h8000_0000); wr(3'd4, 32'h0000_C3A5);
    chk("R8 idle levels with active-high line", 128'(cs_out), 128'hB);
    xfer(2, 16, 1'b0, '0, 1'b1, 1'b1, dcv, 34, cap);
    chk("R8 R11 write phase 1 polarity 1", cap[15:0], 16'hC3A5);
    chk("R8 sclk idles high", 128'(sclk), 128'h1);
    wr(3'd2, 32'h0004_0000);
    chk("R9 active-high line released", 128'(cs_out), 128'hB);
  endtask

  task automatic t_write128;
    logic [127:0] cap;
    logic [31:0] dcv = 32'h0400_0000;
    wr(3'd1, dcv); wr(3'd0, 32'h8000_0000);
    wr(3'd7, 32'h0123_4567); wr(3'd6, 32'h89AB_CDEF);
    wr(3'd5, 32'hF0E1_D2C3); wr(3'd4, 32'hB4A5_9687);
    xfer(3, 128, 1'b0, '0, 1'b0, 1'b1, dcv, 256, cap);
    chk("R5 128-bit word order", cap, 128'h0123_4567_89AB_CDEF_F0E1_D2C3_B4A5_9687);
    wr(3'd2, 32'h0004_0000);
  endtask

  task automatic t_frame_and_ignore;
    logic [127:0] cap;
    logic [31:0] v;
    logic [31:0] dcv = 32'h0400_0000;
    wr(3'd0, 32'h8000_0001);
    xfer(3, 5, 1'b1, 128'h15, 1'b0, 1'b1, dcv, 20, cap);
    rd(3'd4, v); chk("R11 read 5 bits phase 1", 128'(v), 128'h15);
    chk("R9 line held between words", 128'(cs_out), 128'(csx(3, dcv, 1'b1)));
    xfer(3, 8, 1'b1, 128'h6A, 1'b0, 1'b1, dcv, 32, cap);
    rd(3'd4, v); chk("R6 second word of frame", 128'(v), 128'h6A);
    wr(3'd2, 32'h3007_0000);
    rd(3'd3, v); chk("R10 op 7 leaves status", 128'(v), 128'h2);
    chk("R10 op 7 leaves chip select", 128'(cs_out), 128'(csx(3, dcv, 1'b1)));
    rd(3'd4, v); chk("R10 op 7 leaves data", 128'(v), 128'h6A);
    wr(3'd2, 32'h0004_0000);
    chk("R9 op 4 releases line", 128'(cs_out), 128'(csx(3, dcv, 1'b0)));
  endtask

  task automatic t_gate;
    logic [31:0] v;
    wr(3'd1, 32'h0); wr(3'd0, 32'h0000_0000); wr(3'd4, 32'h9);
    wr(3'd2, (32'd3 << 19) | 32'h0002_0000);
    repeat (20) @(negedge clk);
    rd(3'd3, v); chk("R3 stalled while clock disabled", 128'(v), 128'h1);
    chk("R3 sclk idle while disabled", 128'(sclk), 128'h0);
    chk("R4 line 0 active", 128'(cs_out), 128'hE);
    wr(3'd0, 32'h8000_0000);
    for (int i = 0; i < 100; i++) begin
      rd(3'd3, v);
      if (!v[0]) break;
      @(negedge clk);
    end
    chk("R3 completes once enabled", 128'(v), 128'h2);
    wr(3'd2, 32'h0004_0000);
  endtask

  task automatic t_abort;
    logic [31:0] v;
    wr(3'd0, 32'h8000_000A);
    wr(3'd2, (32'd1 << 28) | (32'd127 << 19) | 32'h0002_0000);
    repeat (30) @(negedge clk);
    rd(3'd3, v); chk("R10 long word running", 128'(v), 128'h1);
    wr(3'd2, (32'd2 << 28) | (32'd7 << 19) | 32'h0001_0000);
    rd(3'd2, v); chk("R10 command while busy ignored", 128'(v[29:28]), 128'h1);
    wr(3'd2, 32'h0);
    rd(3'd3, v); chk("R10 zero command aborts", 128'(v), 128'h0);
    chk("R10 zero command releases", 128'(cs_out), 128'hF);
    wr(3'd1, 32'h0); wr(3'd4, 32'h0);
    rd(3'd4, v); chk("R10 data cleared", 128'(v), 128'h0);
    chk("R10 idle outputs", 128'({cs_out, sclk}), 128'h1E);
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; miso = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write_mode0();
    t_read_mode0();
    t_mode3_delay();
    t_write128();
    t_frame_and_ignore();
    t_gate();
    t_abort();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule